// File: doc/BRIEF.md
# Opcode-Driven Integer ALU

This block is the purely combinational datapath of an integer execute stage. It takes two operand words, a separate shift distance and a 6-bit function code laid out like the R-type function field. From these it forms one result word and three condition flags: zero, overflow and carry-out. No register lies on any path, so the outputs settle in the same cycle the inputs change. The surrounding pipeline registers the outputs as it needs.

The function codes cover several groups:
- shifts, with the distance taken either from the shift-distance port or from the low bits of operand B;
- signed and unsigned addition and subtraction;
- the four bitwise operations;
- signed and unsigned less-than compares.

Two codes fall outside the usual function-field set. One passes operand A through unchanged for register-indirect jumps. The other moves operand B up by half a word to form an upper immediate. Every code outside this set gives a quiet output.

Top module: `word_alu`

## Requirements
- R1: Code 000000 shifts operand A left, 000010 shifts it right logically and 000011 shifts it right arithmetically, each by `shamt_i`.
- R2: Codes 000100, 000110 and 000111 perform the same three shifts, by the value of `op_b_i[4:0]`.
- R3: Codes 001000 and 001001 return operand A unchanged.
- R4: Codes 101000 and 101001 return operand B shifted left by 16, with the low 16 bits zero.
- R5: Codes 100000 and 100001 return A+B modulo 2^32, and `carry_o` is the carry out of bit 31.
- R6: Codes 100010 and 100011 return A-B modulo 2^32, and `carry_o` is 1 exactly when A >= B as unsigned values (no borrow).
- R7: `ovf_o` is 1 only for code 100000 when both operands have the same sign and the result sign differs, and for code 100010 when the operand signs differ and the result sign differs from A. It is 0 for every other code.
- R8: Codes 100100, 100101, 100110 and 100111 return bitwise AND, OR, XOR and NOR of A and B.
- R9: Code 101010 returns 1 when A < B as signed values, and code 101011 returns 1 when A < B as unsigned values. Otherwise the result is 0.
- R10: For every defined code, `zero_o` is 1 exactly when the result equals 0.
- R11: Every code not listed in R1 to R9 gives result 0 with `zero_o`, `ovf_o` and `carry_o` all 0.
- R12: `carry_o` is 0 for every code outside 100000 to 100011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B |
| shamt_i | input | 5 | Shift distance for the fixed-distance shift codes |
| func_i | input | 6 | Function code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | Result is zero (defined codes only) |
| ovf_o | output | 1 | Signed overflow of signed add or subtract |
| carry_o | output | 1 | Carry out of add, or no-borrow of subtract |

## Verification
The bench focuses on the edges of the shift range. A shift by 0 must leave the word unchanged, a shift by 31 must keep or drop a single bit, and an arithmetic right shift of a negative word must fill with ones; a shifter with a mis-wired stage or a zero fill would return the wrong word. For add and subtract it drives the wrap points 0x7FFFFFFF+1, 0xFFFFFFFF+1, 0-1 and 0x80000000-1. A design that reported overflow for the unsigned codes, or treated carry as borrow, would raise the wrong flag there. For the compares it uses operand pairs whose signed and unsigned order disagree, which exposes any swap of the two compare kinds. Undefined codes, including the neighbours of defined ones and the multiply and move codes, show whether a design leaks a result or a stale zero flag.

// File: rtl/alu_fn_pkg.sv
package alu_fn_pkg;

  // Direction of the barrel shifter
  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;

  // Bitwise operation of the logic unit
  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_op_e;

  // Result source selected by the decoder
  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_SHIFT = 3'd1,
    SRC_ARITH = 3'd2,
    SRC_LOGIC = 3'd3,
    SRC_LESS  = 3'd4,
    SRC_PASS  = 3'd5,
    SRC_UPPER = 3'd6
  } res_src_e;

  typedef struct packed {
    logic        valid;
    res_src_e    src;
    shift_kind_e sh_kind;
    logic        sh_var;
    logic        subtract;
    logic        unsigned_op;
    logic_op_e   lg_op;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_barrel_shift.sv
module alu_barrel_shift
  import alu_fn_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] dist_i,
  input  shift_kind_e   kind_i,
  output logic [W-1:0]  data_o
);

  logic fill;
  logic left;
  logic [W-1:0] stage [SW+1];

  assign fill     = (kind_i == SH_RARI) & data_i[W-1];
  assign left     = (kind_i == SH_LEFT);
  assign stage[0] = data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [W-1:0] moved;
    always_comb begin
      if (left) moved = {stage[k][W-1-STEP:0], {STEP{1'b0}}};
      else      moved = {{STEP{fill}}, stage[k][W-1:STEP]};
    end
    assign stage[k+1] = dist_i[k] ? moved : stage[k];
  end

  assign data_o = stage[SW];

  // R1/R2: a left shift by a nonzero distance leaves bit 0 clear
  always_comb begin
    if (left && dist_i != '0) a_r1_left_zero_fill: assert (data_o[0] == 1'b0);
  end

  // R1/R2: an arithmetic right shift preserves the sign bit
  always_comb begin
    if (kind_i == SH_RARI) a_r2_sign_kept: assert (data_o[W-1] == data_i[W-1]);
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff   = b_i ^ {W{sub_i}};
  assign wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o   = wide[W-1:0];
  assign carry_o = wide[W];
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) & (sum_o[W-1] != a_i[W-1]);
  assign lt_u_o  = ~carry_o;
  assign lt_s_o  = sum_o[W-1] ^ ovf_o;

  // R6/R9: the no-borrow carry of a subtraction agrees with an unsigned compare
  always_comb begin
    if (sub_i) a_r6_carry_is_no_borrow: assert (carry_o == (a_i >= b_i));
  end

  // R9: the signed less-than agrees with a signed compare
  always_comb begin
    if (sub_i) a_r9_signed_less: assert (lt_s_o == ($signed(a_i) < $signed(b_i)));
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_fn_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_op_e    op_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    unique case (op_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

endmodule

// File: rtl/word_alu.sv
module word_alu
  import alu_fn_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int FN_W  = 6,
  localparam int SHW  = $clog2(WIDTH),
  localparam int HALF = WIDTH / 2
) (
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [FN_W-1:0]  func_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             carry_o
);

  alu_ctrl_t        ctrl;
  logic [SHW-1:0]   sh_dist;
  logic [WIDTH-1:0] sh_y, as_y, lg_y;
  logic             as_c, as_v, as_lts, as_ltu;
  logic             arith_flags;

  // Decoder: function code to control word
  always_comb begin
    ctrl = '{valid: 1'b0, src: SRC_NONE, sh_kind: SH_LEFT, sh_var: 1'b0,
             subtract: 1'b0, unsigned_op: 1'b0, lg_op: LG_AND};
    case (func_i) inside
      6'b000?00, 6'b000?10, 6'b000?11: begin
        ctrl.valid   = 1'b1;
        ctrl.src     = SRC_SHIFT;
        ctrl.sh_var  = func_i[2];
        ctrl.sh_kind = !func_i[1] ? SH_LEFT : (func_i[0] ? SH_RARI : SH_RLOG);
      end
      6'b00100?: begin
        ctrl.valid = 1'b1;
        ctrl.src   = SRC_PASS;
      end
      6'b1000??: begin
        ctrl.valid       = 1'b1;
        ctrl.src         = SRC_ARITH;
        ctrl.subtract    = func_i[1];
        ctrl.unsigned_op = func_i[0];
      end
      6'b1001??: begin
        ctrl.valid = 1'b1;
        ctrl.src   = SRC_LOGIC;
        ctrl.lg_op = logic_op_e'(func_i[1:0]);
      end
      6'b10100?: begin
        ctrl.valid = 1'b1;
        ctrl.src   = SRC_UPPER;
      end
      6'b10101?: begin
        ctrl.valid       = 1'b1;
        ctrl.src         = SRC_LESS;
        ctrl.subtract    = 1'b1;
        ctrl.unsigned_op = func_i[0];
      end
      default: ;
    endcase
  end

  assign sh_dist = ctrl.sh_var ? op_b_i[SHW-1:0] : shamt_i;

  alu_barrel_shift #(.W(WIDTH)) u_shift (
    .data_i (op_a_i),
    .dist_i (sh_dist),
    .kind_i (ctrl.sh_kind),
    .data_o (sh_y)
  );

  alu_addsub #(.W(WIDTH)) u_addsub (
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .sub_i   (ctrl.subtract),
    .sum_o   (as_y),
    .carry_o (as_c),
    .ovf_o   (as_v),
    .lt_s_o  (as_lts),
    .lt_u_o  (as_ltu)
  );

  alu_bitwise #(.W(WIDTH)) u_logic (
    .a_i  (op_a_i),
    .b_i  (op_b_i),
    .op_i (ctrl.lg_op),
    .y_o  (lg_y)
  );

  // Result select
  always_comb begin
    unique case (ctrl.src)
      SRC_SHIFT: result_o = sh_y;
      SRC_ARITH: result_o = as_y;
      SRC_LOGIC: result_o = lg_y;
      SRC_LESS:  result_o = {{(WIDTH-1){1'b0}}, ctrl.unsigned_op ? as_ltu : as_lts};
      SRC_PASS:  result_o = op_a_i;
      SRC_UPPER: result_o = {op_b_i[WIDTH-1-HALF:0], {HALF{1'b0}}};
      default:   result_o = '0;
    endcase
  end

  // Flags
  assign arith_flags = (ctrl.src == SRC_ARITH);
  assign zero_o      = ctrl.valid & ~|result_o;
  assign carry_o     = arith_flags & as_c;
  assign ovf_o       = arith_flags & ~ctrl.unsigned_op & as_v;

  // R7: overflow only on the two signed add/subtract codes
  always_comb begin
    if (ovf_o) a_r7_ovf_signed_only: assert (func_i == 6'b100000 || func_i == 6'b100010);
  end

  // R12: carry only on the add/subtract family
  always_comb begin
    if (carry_o) a_r12_carry_scope: assert (func_i[5:2] == 4'b1000);
  end

  // R11: undefined codes are quiet
  always_comb begin
    if (!ctrl.valid) a_r11_undefined_quiet: assert (result_o == '0 && !zero_o && !ovf_o && !carry_o);
  end

  // R9: set-less-than results are 0 or 1
  always_comb begin
    if (ctrl.src == SRC_LESS) a_r9_less_binary: assert (result_o[WIDTH-1:1] == '0);
  end

  // R3: pass-through returns operand A
  always_comb begin
    if (ctrl.src == SRC_PASS) a_r3_pass_through: assert (result_o == op_a_i);
  end

endmodule

// File: tb/test_word_alu.sv
module test_word_alu;

  logic        clk;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic [4:0]  shamt;
  logic [5:0]  func;
  logic [31:0] result;
  logic        zero, ovf, carry;

  int checks;
  int errors;
  bit done;

  word_alu i_word_alu (
    .op_a_i   (op_a),
    .op_b_i   (op_b),
    .shamt_i  (shamt),
    .func_i   (func),
    .result_o (result),
    .zero_o   (zero),
    .ovf_o    (ovf),
    .carry_o  (carry)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference model
  task automatic model(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] s, output logic [31:0] r, output logic z,
                       output logic v, output logic c, output string tag);
    longint unsigned wide;
    bit ok;
    ok = 1'b1; v = 1'b0; c = 1'b0; r = '0; tag = "R11";
    case (f)
      6'b000000: begin r = a << s; tag = "R1"; end
      6'b000010: begin r = a >> s; tag = "R1"; end
      6'b000011: begin r = $unsigned($signed(a) >>> s); tag = "R1"; end
      6'b000100: begin r = a << b[4:0]; tag = "R2"; end
      6'b000110: begin r = a >> b[4:0]; tag = "R2"; end
      6'b000111: begin r = $unsigned($signed(a) >>> b[4:0]); tag = "R2"; end
      6'b001000, 6'b001001: begin r = a; tag = "R3"; end
      6'b101000, 6'b101001: begin r = b * 32'd65536; tag = "R4"; end
      6'b100000, 6'b100001: begin
        wide = longint'(a) + longint'(b);
        r = wide[31:0]; c = wide[32]; tag = "R5";
        if (f == 6'b100000) begin
          v = (a[31] == b[31]) && (r[31] != a[31]); tag = "R5/R7";
        end
      end
      6'b100010, 6'b100011: begin
        r = a - b; c = (a >= b); tag = "R6";
        if (f == 6'b100010) begin
          v = (a[31] != b[31]) && (r[31] != a[31]); tag = "R6/R7";
        end
      end
      6'b100100: begin r = a & b; tag = "R8"; end
      6'b100101: begin r = a | b; tag = "R8"; end
      6'b100110: begin r = a ^ b; tag = "R8"; end
      6'b100111: begin r = ~(a | b); tag = "R8"; end
      6'b101010: begin r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R9"; end
      6'b101011: begin r = (a < b) ? 32'd1 : 32'd0; tag = "R9"; end
      default: ok = 1'b0;
    endcase
    z = ok && (r == 32'd0);
  endtask

  // Drive one vector at a rising edge, compare at the falling edge
  task automatic apply(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] s);
    logic [31:0] er;
    logic ez, ev, ec;
    string tag;
    @(posedge clk);
    func = f; op_a = a; op_b = b; shamt = s;
    model(f, a, b, s, er, ez, ev, ec, tag);
    @(negedge clk);
    checks++;
    if (result !== er || zero !== ez || ovf !== ev || carry !== ec) begin
      errors++;
      $display("FAIL %s/R10/R12 func=%b a=%h b=%h s=%0d: got r=%h z=%b v=%b c=%b, expected r=%h z=%b v=%b c=%b",
               tag, f, a, b, s, result, zero, ovf, carry, er, ez, ev, ec);
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    func = '0; op_a = '0; op_b = '0; shamt = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero inputs give a zero result, R10 zero flag set
    apply(6'b000000, 32'h0, 32'h0, 5'd0);

    // R1 fixed-distance shifts at the range edges
    apply(6'b000000, 32'h8000_0001, 32'h0, 5'd0);
    apply(6'b000000, 32'h0000_0001, 32'h0, 5'd31);
    apply(6'b000010, 32'h8000_0000, 32'h0, 5'd31);
    apply(6'b000011, 32'h8000_0000, 32'h0, 5'd31);
    apply(6'b000011, 32'h7000_0000, 32'h0, 5'd4);
    // R2 variable shifts use only the low 5 bits of B
    apply(6'b000100, 32'h0000_00F0, 32'hFFFF_FFE4, 5'd9);
    apply(6'b000110, 32'hF000_0000, 32'h0000_0020, 5'd7);
    apply(6'b000111, 32'h8000_0000, 32'h0000_003F, 5'd0);
    // R3 pass-through, R4 upper immediate
    apply(6'b001000, 32'hDEAD_BEEF, 32'h1234_5678, 5'd3);
    apply(6'b001001, 32'h0000_0000, 32'hFFFF_FFFF, 5'd3);
    apply(6'b101000, 32'h1111_1111, 32'hABCD_1234, 5'd0);
    apply(6'b101001, 32'h0, 32'hFFFF_0000, 5'd0);
    // R5/R7 add wrap points
    apply(6'b100000, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0);
    apply(6'b100001, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0);
    apply(6'b100000, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    apply(6'b100000, 32'h8000_0000, 32'h8000_0000, 5'd0);
    // R6/R7 subtract wrap points
    apply(6'b100010, 32'h0000_0000, 32'h0000_0001, 5'd0);
    apply(6'b100011, 32'h0000_0005, 32'h0000_0005, 5'd0);
    apply(6'b100010, 32'h8000_0000, 32'h0000_0001, 5'd0);
    apply(6'b100011, 32'h8000_0000, 32'h0000_0001, 5'd0);
    // R8 logic
    apply(6'b100100, 32'hF0F0_F0F0, 32'hFF00_FF00, 5'd0);
    apply(6'b100101, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 5'd0);
    apply(6'b100110, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 5'd0);
    apply(6'b100111, 32'h0, 32'h0, 5'd0);
    // R9 compares where signed and unsigned order differ
    apply(6'b101010, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    apply(6'b101011, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    apply(6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    apply(6'b101011, 32'h1234_5678, 32'h1234_5678, 5'd0);
    // R11 undefined codes, including neighbours and multiply/move codes
    apply(6'b000001, 32'h0, 32'h0, 5'd0);
    apply(6'b000101, 32'hFFFF_FFFF, 32'h1, 5'd1);
    apply(6'b011000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd0);
    apply(6'b010000, 32'h1, 32'h1, 5'd0);
    apply(6'b111111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31);
    apply(6'b101100, 32'h0, 32'h0, 5'd0);

    // Sweep: every code with pseudo-random operands
    for (int n = 0; n < 40; n++) begin
      for (int f = 0; f < 64; f++) begin
        apply(6'(f), $urandom, $urandom, 5'($urandom));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion within 100000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule